// File: doc/BRIEF.md
# I2C Slave Address Matcher with Bit Masking

This block handles the address phase of an I2C target device. It watches the already synchronised SCL and SDA lines and recognises START, repeated START and STOP conditions. It shifts in the first byte, or the first two bytes in 10-bit mode, and compares the received address with a programmed own address. Any address bit whose mask bit is set is treated as don't-care. One own address can therefore answer to up to 32 seven-bit addresses or 64 ten-bit addresses.

On a match the block pulls SDA low for the acknowledge clock. It also issues a one-cycle match interrupt and keeps the received address byte, so software can tell which of the masked addresses was hit. On a mismatch SDA stays released, and the block ignores the bus until the next START. It does not acknowledge any byte after the address phase. Data transfer, clock stretching and general call are handled elsewhere.

Top module: `i2c_mask_addr_match`

## Requirements
- R1: After synchronous reset, `sda_pull_low` and `match_irq` are 0, `rx_addr` is 0x00, and the block waits for a START.
- R2: A START is SDA falling while SCL is high. A START at any point, including a repeated START, restarts address reception from the first byte. A STOP is SDA rising while SCL is high, and it returns the block to idle with SDA released. Bits clocked after a STOP without a new START are never acknowledged.
- R3: In 7-bit mode (`ten_bit_mode`=0) the received byte is {address[6:0], R/W}. Byte bits 7..1 are compared with `own_addr[6:0]`, and byte bit 0 is never compared. `addr_mask[k]` (k = 0..4) makes byte bit k+1 a don't-care. With own byte 0xA0 and mask 5'b00111, every byte 0xA0..0xAF matches, and 0xB0 and 0x20 do not.
- R4: In 10-bit mode the first byte is the header {5'b11110, A9, A8, R/W}. It matches only if bits 7..3 equal 11110 and bits 2..1 equal `own_addr[9:8]`, whatever the mask value.
- R5: In 10-bit mode the second byte is compared with `own_addr[7:0]`. `addr_mask[4:1]` mask bits 5..2, `addr_mask[0]` masks bits 1 and 0 together, and bits 7..6 are always compared. With low byte 0xA0 and mask 5'b00111, bytes 0xA0..0xAF match.
- R6: For each matching byte, `sda_pull_low` rises within SCL low after the eighth data clock. It stays high through the whole ninth SCL high period and falls on the cycle after the ninth SCL falling edge.
- R7: On a mismatch at any address byte, SDA is not pulled during that byte's ninth clock. The block ignores every later byte until the next START.
- R8: `match_irq` is a one-cycle pulse that rises together with the acknowledge of the final address byte: the only byte in 7-bit mode, the low byte in 10-bit mode. A matching 10-bit header alone raises no interrupt.
- R9: When `match_irq` pulses, `rx_addr` holds the received final address byte: the full byte including R/W in 7-bit mode, the low byte in 10-bit mode. It keeps this value until the next match.
- R10: With `addr_mask` all zero, only the exact own address is acknowledged, in both modes.
- R11: After the address phase is acknowledged, later bytes get no acknowledge from this block until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ten_bit_mode | input | 1 | 1 selects 10-bit addressing, 0 selects 7-bit |
| own_addr | input | 10 | Own address; bits 6..0 are used in 7-bit mode, bits 9..0 in 10-bit mode |
| addr_mask | input | 5 | Per-bit don't-care mask; mapping depends on mode |
| scl_in | input | 1 | Synchronised SCL line level |
| sda_in | input | 1 | Synchronised SDA line level |
| sda_pull_low | output | 1 | 1 drives SDA low (acknowledge) |
| match_irq | output | 1 | One-cycle pulse on a completed address match |
| rx_addr | output | 8 | Last matched address byte |

## Verification
The bench sweeps every byte of a masked address window in both modes. It also probes the bits just outside each window: byte bit 4 in 7-bit mode, low bits 7..6 in 10-bit mode, and header bits A9:A8 with a full mask. A matcher that mapped the mask one bit off, or let the mask reach bits it must not cover, would acknowledge or refuse the wrong bytes there. Single-bit masks check that mask bit 0 covers two low bits in 10-bit mode but only one in 7-bit mode.

A second byte after a refused or accepted address exposes a design that keeps acknowledging past the address phase. A STOP in the middle of a byte, and a repeated START after a partial byte, expose bit counters that are not cleared. Each acknowledge is also checked after the ninth clock, so a release that is late or missing shows up.

// File: rtl/i2c_amm_pkg.sv
package i2c_amm_pkg;
  localparam int BYTE_W  = 8;
  localparam int MASK_W  = 5;
  localparam int ADDR_W  = 10;
  localparam int CNT_W   = $clog2(BYTE_W + 2);
  localparam logic [4:0] HDR_PREFIX = 5'b11110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX1,
    ST_ACK1,
    ST_RX2,
    ST_ACK2,
    ST_HOLD
  } amm_state_t;
endpackage

// File: rtl/i2c_amm_bus_events.sv
module i2c_amm_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_in;
      sda_q <= sda_in;
    end
  end

  assign scl_rise  = !scl_q && scl_in;
  assign scl_fall  = scl_q && !scl_in;
  assign start_det = scl_q && scl_in && sda_q && !sda_in;
  assign stop_det  = scl_q && scl_in && !sda_q && sda_in;

  a_r2_start_stop_excl: assert property (@(posedge clk) disable iff (rst)
    !(start_det && stop_det));
endmodule

// File: rtl/i2c_amm_shifter.sv
module i2c_amm_shifter #(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              scl_rise,
  input  logic              sda_in,
  output logic [BYTE_W-1:0] shreg,
  output logic              byte_full,
  output logic              ninth_seen
);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] NINTH_CNT = CNT_W'(BYTE_W + 1);

  logic [CNT_W-1:0] bit_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (clear) begin
      bit_cnt <= '0;
    end else if (scl_rise && bit_cnt != NINTH_CNT) begin
      if (bit_cnt != FULL_CNT) shreg <= {shreg[BYTE_W-2:0], sda_in};
      bit_cnt <= bit_cnt + 1'b1;
    end
  end

  assign byte_full  = (bit_cnt == FULL_CNT);
  assign ninth_seen = (bit_cnt == NINTH_CNT);

  // R6: counter never passes the acknowledge slot
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= NINTH_CNT);
endmodule

// File: rtl/i2c_amm_compare.sv
module i2c_amm_compare
  import i2c_amm_pkg::*;
(
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [MASK_W-1:0] addr_mask,
  input  logic              ten_bit_mode,
  input  logic              is_header,
  output logic              hit
);
  logic [BYTE_W-1:0] ign7, ign10, own7;
  logic hit7, hit_hdr, hit_low;

  always_comb begin
    own7    = {own_addr[6:0], 1'b0};
    ign7    = {2'b00, addr_mask, 1'b1};
    ign10   = {2'b00, addr_mask[4:1], {2{addr_mask[0]}}};
    hit7    = (((rx_byte ^ own7) & ~ign7) == '0);
    hit_low = (((rx_byte ^ own_addr[7:0]) & ~ign10) == '0);
    hit_hdr = (rx_byte[7:3] == HDR_PREFIX) && (rx_byte[2:1] == own_addr[9:8]);
    if (!ten_bit_mode) hit = hit7;
    else if (is_header) hit = hit_hdr;
    else hit = hit_low;
  end

  always_comb begin
    // R10: an empty mask reduces to exact equality
    if (!ten_bit_mode && addr_mask == '0 && hit)
      a_r10_exact7: assert (rx_byte[7:1] == own_addr[6:0]);
    // R4: a header hit always carries the fixed prefix
    if (ten_bit_mode && is_header && hit)
      a_r4_hdr_prefix: assert (rx_byte[7:3] == 5'b11110);
  end
endmodule

// File: rtl/i2c_mask_addr_match.sv
module i2c_mask_addr_match
  import i2c_amm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ten_bit_mode,
  input  logic [9:0]        own_addr,
  input  logic [4:0]        addr_mask,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_pull_low,
  output logic              match_irq,
  output logic [7:0]        rx_addr
);
  amm_state_t state;
  logic scl_rise, scl_fall, start_det, stop_det;
  logic [BYTE_W-1:0] shreg;
  logic byte_full, ninth_seen, hit, is_header, ack_done, sh_clear;

  i2c_amm_bus_events u_events (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign ack_done = (state == ST_ACK1 || state == ST_ACK2) && scl_fall && ninth_seen;
  assign sh_clear = start_det || ack_done;

  i2c_amm_shifter #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst(rst), .clear(sh_clear), .scl_rise(scl_rise),
    .sda_in(sda_in), .shreg(shreg), .byte_full(byte_full),
    .ninth_seen(ninth_seen)
  );

  assign is_header = (state == ST_RX1) && ten_bit_mode;

  i2c_amm_compare u_cmp (
    .rx_byte(shreg), .own_addr(own_addr), .addr_mask(addr_mask),
    .ten_bit_mode(ten_bit_mode), .is_header(is_header), .hit(hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      sda_pull_low <= 1'b0;
      match_irq    <= 1'b0;
      rx_addr      <= '0;
    end else begin
      match_irq <= 1'b0;
      if (start_det) begin
        state        <= ST_RX1;
        sda_pull_low <= 1'b0;
      end else if (stop_det) begin
        state        <= ST_IDLE;
        sda_pull_low <= 1'b0;
      end else begin
        case (state)
          ST_RX1, ST_RX2: begin
            if (scl_fall && byte_full) begin
              if (hit) begin
                sda_pull_low <= 1'b1;
                state        <= (state == ST_RX1) ? ST_ACK1 : ST_ACK2;
                if (!is_header) begin
                  match_irq <= 1'b1;
                  rx_addr   <= shreg;
                end
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_ACK1: if (ack_done) begin
            sda_pull_low <= 1'b0;
            state        <= ten_bit_mode ? ST_RX2 : ST_HOLD;
          end
          ST_ACK2: if (ack_done) begin
            sda_pull_low <= 1'b0;
            state        <= ST_HOLD;
          end
          default: state <= state;
        endcase
      end
    end
  end

  // R8: interrupt lasts one cycle
  a_r8_irq_pulse: assert property (@(posedge clk) disable iff (rst)
    match_irq |=> !match_irq);
  // R8: interrupt coincides with acknowledge
  a_r8_irq_with_ack: assert property (@(posedge clk) disable iff (rst)
    match_irq |-> sda_pull_low);
  // R6: acknowledge only begins while SCL is low
  a_r6_ack_starts_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull_low) |-> !scl_in);
  // R6: acknowledge is held while SCL is high
  a_r6_ack_held_high: assert property (@(posedge clk) disable iff (rst)
    (sda_pull_low && scl_in && !start_det && !stop_det) |=> sda_pull_low);
  // R2: stop returns to idle with SDA released
  a_r2_stop_idle: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (state == ST_IDLE && !sda_pull_low));
endmodule

// File: tb/test_i2c_mask_addr_match.sv
module test_i2c_mask_addr_match;
  localparam int CLK_P = 10;
  localparam int PH    = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ten_bit_mode = 1'b0;
  logic [9:0] own_addr = '0;
  logic [4:0] addr_mask = '0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_line;
  logic sda_pull_low, match_irq;
  logic [7:0] rx_addr;

  int checks = 0, fails = 0;
  bit done = 0;
  bit prev_irq = 0;
  logic [7:0] exp_q[$];
  logic [7:0] last_hit = 8'h00;

  always #(CLK_P/2) clk = ~clk;
  assign sda_line = sda_m & ~sda_pull_low;

  i2c_mask_addr_match i_i2c_mask_addr_match (
    .clk(clk), .rst(rst), .ten_bit_mode(ten_bit_mode), .own_addr(own_addr),
    .addr_mask(addr_mask), .scl_in(scl), .sda_in(sda_line),
    .sda_pull_low(sda_pull_low), .match_irq(match_irq), .rx_addr(rx_addr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: R8 / R9
  always @(negedge clk) begin
    if (!rst) begin
      if (match_irq) begin
        chk(!prev_irq, "R8 irq longer than one cycle", 1, 0);
        if (exp_q.size() == 0) chk(0, "R8 unexpected irq", rx_addr, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(rx_addr == e, "R9 rx_addr at irq", rx_addr, e);
        end
      end
      prev_irq = match_irq;
    end
  end

  task automatic phase();
    repeat (PH) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; phase(); scl = 1'b1; phase();
    sda_m = 1'b0; phase(); scl = 1'b0; phase();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; phase(); scl = 1'b1; phase(); sda_m = 1'b1; phase();
  endtask

  task automatic clock_bit(input logic b);
    sda_m = b; phase(); scl = 1'b1; phase(); scl = 1'b0; phase();
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack,
                           input bit exp_irq, input string tag);
    if (exp_irq) begin
      exp_q.push_back(b);
      last_hit = b;
    end
    for (int i = 7; i >= 0; i--) clock_bit(b[i]);
    sda_m = 1'b1; phase();
    chk(sda_pull_low == exp_ack, {tag, " ack before 9th high"}, sda_pull_low, exp_ack);
    scl = 1'b1; phase();
    chk(sda_pull_low == exp_ack, {tag, " ack in 9th high (R6)"}, sda_pull_low, exp_ack);
    scl = 1'b0; phase();
    chk(sda_pull_low == 1'b0, {tag, " release after 9th (R6)"}, sda_pull_low, 0);
  endtask

  function automatic bit exp7(input logic [7:0] b);
    logic [7:0] ob;
    ob = {own_addr[6:0], 1'b0};
    for (int i = 1; i < 8; i++) begin
      if (i <= 5 && addr_mask[i-1]) continue;
      if (b[i] != ob[i]) return 0;
    end
    return 1;
  endfunction

  function automatic bit exp_hdr(input logic [7:0] b);
    return (b[7:3] == 5'b11110) && (b[2] == own_addr[9]) && (b[1] == own_addr[8]);
  endfunction

  function automatic bit exp_low(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      if (i >= 2 && i <= 5 && addr_mask[i-1]) continue;
      if (i <= 1 && addr_mask[0]) continue;
      if (b[i] != own_addr[i]) return 0;
    end
    return 1;
  endfunction

  task automatic xact7(input logic [7:0] b, input string tag);
    bit e;
    e = exp7(b);
    bus_start();
    send_byte(b, e, e, tag);
    if (e) send_byte(8'h55, 0, 0, "R11");
    else   send_byte(b, 0, 0, "R7");
    bus_stop();
  endtask

  task automatic xact10(input logic [7:0] h, input logic [7:0] l, input string tag);
    bit eh, el;
    eh = exp_hdr(h);
    el = eh && exp_low(l);
    bus_start();
    send_byte(h, eh, 0, tag);
    send_byte(l, el, el, tag);
    if (el) send_byte(8'h0F, 0, 0, "R11");
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(sda_pull_low == 0, "R1 sda_pull_low reset", sda_pull_low, 0);
    chk(match_irq == 0, "R1 match_irq reset", match_irq, 0);
    chk(rx_addr == 8'h00, "R1 rx_addr reset", rx_addr, 0);

    // 7-bit, exact (R3, R10)
    own_addr = 10'h050; addr_mask = 5'b00000;
    xact7(8'hA0, "R10");
    xact7(8'hA1, "R3");
    xact7(8'hA2, "R10");
    xact7(8'h20, "R10");

    // 7-bit masked window (R3)
    addr_mask = 5'b00111;
    for (int b = 8'hA0; b <= 8'hAF; b++) xact7(8'(b), "R3");
    xact7(8'hB0, "R3");
    xact7(8'h20, "R3");
    addr_mask = 5'b01000;
    xact7(8'hB0, "R3");
    xact7(8'hA2, "R3");

    // repeated START after partial byte (R2)
    addr_mask = 5'b00000;
    bus_start();
    clock_bit(1'b0); clock_bit(1'b0); clock_bit(1'b1);
    scl = 1'b0;
    bus_start();
    send_byte(8'hA0, 1, 1, "R2");
    bus_stop();

    // STOP mid-byte, then clocking without START (R2)
    bus_start();
    clock_bit(1'b1); clock_bit(1'b0); clock_bit(1'b1); clock_bit(1'b0);
    bus_stop();
    scl = 1'b0; phase();
    send_byte(8'hA0, 0, 0, "R2");
    bus_stop();

    // 10-bit mode (R4, R5)
    ten_bit_mode = 1'b1; own_addr = 10'h2A0; addr_mask = 5'b00111;
    for (int b = 8'hA0; b <= 8'hAF; b++) xact10(8'hF4, 8'(b), "R5");
    xact10(8'hF4, 8'hB0, "R5");
    xact10(8'hF4, 8'h60, "R5");
    xact10(8'hF6, 8'hA0, "R4");
    xact10(8'hE4, 8'hA0, "R4");
    addr_mask = 5'b00001;
    xact10(8'hF4, 8'hA3, "R5");
    xact10(8'hF4, 8'hA4, "R5");
    addr_mask = 5'b11111;
    xact10(8'hF4, 8'h80, "R5");
    xact10(8'hF4, 8'hBF, "R5");
    xact10(8'hF4, 8'h40, "R5");
    xact10(8'hF2, 8'hA0, "R4");
    addr_mask = 5'b00000;
    xact10(8'hF4, 8'hA0, "R10");
    xact10(8'hF4, 8'hA1, "R10");

    // 7-bit: mask bit 0 covers only one bit (R3)
    ten_bit_mode = 1'b0; own_addr = 10'h050; addr_mask = 5'b00001;
    xact7(8'hA3, "R3");
    xact7(8'hA5, "R3");
    xact7(8'hA4, "R3");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R8 missing irq", exp_q.size(), 0);
    chk(rx_addr == last_hit, "R9 rx_addr held", rx_addr, last_hit);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule